// File: doc/BRIEF.md
# IDE DMA Write FIFO Controller

This block sits between the PCI-side bus-master engine and an IDE device during multiword DMA writes. The PCI side fills a 16-word FIFO. The device asks for data on its request line and takes one word on every cycle in which the block acknowledges. While a transfer is running, an idle timer watches the request line. If the device holds the request low for longer than a set number of clock cycles, the FIFO is flushed.

A flush lasts two cycles. During those cycles every fill from the PCI side is refused, so a prefetch that arrives late cannot leave stale words behind after the pointers have been cleared. Once the flush ends, the block acknowledges the next request as soon as new data is present. Software controls the transfer with a run bit. Clearing the bit aborts the transfer and puts the block back into its reset state. Setting it again allows the transfer to be retried. A watchdog flag reports a device request that has gone unacknowledged for a programmable number of cycles.

Top module: `ide_dma_wr_fifo`

## Requirements
- R1: After reset, empty_o=1, full_o=0, level_o=0, dack_o=0, invalidating_o=0 and wdog_o=0.
- R2: Accepted fill words appear on dev_data_o in the order they were accepted, and one word is removed on each cycle in which dack_o is high.
- R3: With DEPTH words stored, full_o=1 and fill_ready_o=0, and further fills are dropped. Exactly DEPTH words are delivered afterwards.
- R4: dack_o is high exactly when run_i=1, dreq_i=1, the FIFO is not empty and no flush is in progress.
- R5: The idle timer runs only in multiword DMA mode (mode_i=2'd1) and only after dreq_i has been sampled high. When dreq_i is sampled low on IDLE_CYCLES consecutive edges, invalidating_o rises after the last of those edges. A shorter low period has no effect.
- R6: invalidating_o stays high for exactly 2 cycles. When it falls, the FIFO is empty and level_o=0.
- R7: While invalidating_o=1, fill_ready_o=0, and a fill presented during that time never enters the FIFO.
- R8: After a flush, new fills are accepted. When dreq_i is reasserted, the new words are acknowledged and delivered, and no further flush occurs until dreq_i has been seen high again.
- R9: In PIO mode (mode_i=2'd0) and Ultra DMA mode (mode_i=2'd2), a long low period on dreq_i never starts a flush.
- R10: While run_i=0, the FIFO, the idle timer, the flush sequence and the watchdog are held cleared, dack_o=0 and fills are ignored. After run_i returns to 1, transfers proceed normally.
- R11: wdog_o is set after wdog_limit_i consecutive cycles with run_i=1, dreq_i=1 and dack_o=0. It stays set until run_i is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start/stop control; 0 aborts and clears the transfer |
| mode_i | input | 2 | Transfer mode: 0 PIO, 1 multiword DMA, 2 Ultra DMA |
| wdog_limit_i | input | WD_W | Number of unacknowledged request cycles before wdog_o is set |
| fill_valid_i | input | 1 | PCI-side fill word valid |
| fill_data_i | input | WIDTH | PCI-side fill word |
| fill_ready_o | output | 1 | Fill is accepted in this cycle |
| dreq_i | input | 1 | Device DMA request |
| dack_o | output | 1 | DMA acknowledge; a word is taken in this cycle |
| dev_data_o | output | WIDTH | Word at the head of the FIFO |
| full_o | output | 1 | FIFO full |
| empty_o | output | 1 | FIFO empty |
| level_o | output | LVL_W | Number of stored words |
| invalidating_o | output | 1 | Flush in progress |
| wdog_o | output | 1 | Request not acknowledged in time (sticky) |

## Verification
The key corner case is a PCI fill that arrives during the two flush cycles. A design without the interlock would leave a stale word in a FIFO that should be empty, and it would then acknowledge the device with that word. The bench also counts the idle period edge by edge: an off-by-one timer would flush one cycle early or one cycle late. After the flush, the bench reasserts the request to catch a controller that stays locked up. It drives overfill attempts to catch a design that overwrites a full FIFO. It also checks that the PIO and Ultra DMA modes never flush, and that clearing the run bit wipes both the stored words and the sticky watchdog.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  typedef enum logic [1:0] {
    XFER_PIO   = 2'd0,
    XFER_MWDMA = 2'd1,
    XFER_UDMA  = 2'd2
  } xfer_mode_e;

  typedef enum logic {
    SEQ_WAIT  = 1'b0,
    SEQ_FLUSH = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dmaw_fifo.sv
module dmaw_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o
);
  localparam int PW = AW + 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q, diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + PW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && !clr_i && wr_ptr_q[AW-1:0] == AW'(g)) mem_q[g] <= data_i;
    end
  end

  assign diff    = wr_ptr_q - rd_ptr_q;
  assign data_o  = mem_q[rd_ptr_q[AW-1:0]];
  assign empty_o = (diff == '0);
  assign full_o  = (diff == PW'(DEPTH));
  assign level_o = LVL_W'(diff);
endmodule

// File: rtl/dmaw_idle_seq.sv
module dmaw_idle_seq #(
  parameter int IDLE_CYCLES  = 33,
  parameter int FLUSH_CYCLES = 2,
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1),
  localparam int FL_W  = $clog2(FLUSH_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic mwdma_i,
  input  logic dreq_i,
  output logic flush_o
);
  import dmaw_pkg::*;

  seq_state_e       state_q;
  logic             armed_q;
  logic [CNT_W-1:0] idle_cnt_q;
  logic [FL_W-1:0]  fl_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_WAIT;
      armed_q    <= 1'b0;
      idle_cnt_q <= '0;
      fl_cnt_q   <= '0;
    end else if (!run_i) begin
      state_q    <= SEQ_WAIT;
      armed_q    <= 1'b0;
      idle_cnt_q <= '0;
      fl_cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_WAIT: begin
          if (dreq_i) begin
            armed_q    <= 1'b1;
            idle_cnt_q <= '0;
          end else if (armed_q && mwdma_i) begin
            if (idle_cnt_q == CNT_W'(IDLE_CYCLES - 1)) begin
              state_q    <= SEQ_FLUSH;
              armed_q    <= 1'b0;  // rearm only after dreq is seen again
              idle_cnt_q <= '0;
              fl_cnt_q   <= '0;
            end else begin
              idle_cnt_q <= idle_cnt_q + CNT_W'(1);
            end
          end else begin
            idle_cnt_q <= '0;
          end
        end
        SEQ_FLUSH: begin
          if (fl_cnt_q == FL_W'(FLUSH_CYCLES - 1)) begin
            state_q  <= SEQ_WAIT;
            fl_cnt_q <= '0;
          end else begin
            fl_cnt_q <= fl_cnt_q + FL_W'(1);
          end
        end
        default: state_q <= SEQ_WAIT;
      endcase
    end
  end

  assign flush_o = (state_q == SEQ_FLUSH);
endmodule

// File: rtl/dmaw_wdog.sv
module dmaw_wdog #(
  parameter int WD_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            wait_i,
  input  logic [WD_W-1:0] limit_i,
  output logic            trip_o
);
  logic [WD_W-1:0] cnt_q;
  logic [WD_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt_q} + (WD_W + 1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trip_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      trip_o <= 1'b0;
    end else if (wait_i) begin
      if (cnt_q != '1) cnt_q <= next_cnt[WD_W-1:0];
      if (next_cnt >= {1'b0, limit_i}) trip_o <= 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/ide_dma_wr_fifo.sv
module ide_dma_wr_fifo #(
  parameter int WIDTH       = 32,
  parameter int DEPTH       = 16,
  parameter int IDLE_CYCLES = 33,
  parameter int WD_W        = 16,
  localparam int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       mode_i,
  input  logic [WD_W-1:0]  wdog_limit_i,
  input  logic             fill_valid_i,
  input  logic [WIDTH-1:0] fill_data_i,
  output logic             fill_ready_o,
  input  logic             dreq_i,
  output logic             dack_o,
  output logic [WIDTH-1:0] dev_data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o,
  output logic             invalidating_o,
  output logic             wdog_o
);
  import dmaw_pkg::*;

  localparam int FLUSH_CYCLES = 2;

  logic flush, push, pop, clr;

  dmaw_idle_seq #(
    .IDLE_CYCLES (IDLE_CYCLES),
    .FLUSH_CYCLES(FLUSH_CYCLES)
  ) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .mwdma_i(mode_i == XFER_MWDMA),
    .dreq_i (dreq_i),
    .flush_o(flush)
  );

  // fills are interlocked against the flush so a late prefetch is dropped
  assign fill_ready_o = run_i && !flush && !full_o;
  assign push         = fill_valid_i && fill_ready_o;
  assign dack_o       = run_i && dreq_i && !flush && !empty_o;
  assign pop          = dack_o;
  assign clr          = !run_i || flush;

  dmaw_fifo #(
    .WIDTH(WIDTH),
    .DEPTH(DEPTH)
  ) i_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .push_i (push),
    .data_i (fill_data_i),
    .pop_i  (pop),
    .data_o (dev_data_o),
    .full_o (full_o),
    .empty_o(empty_o),
    .level_o(level_o)
  );

  dmaw_wdog #(
    .WD_W(WD_W)
  ) i_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .wait_i (run_i && dreq_i && !dack_o),
    .limit_i(wdog_limit_i),
    .trip_o (wdog_o)
  );

  assign invalidating_o = flush;
endmodule

// File: rtl/dmaw_chk.sv
module dmaw_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic [1:0] mode_i,
  input logic       dreq_i,
  input logic       fill_ready_o,
  input logic       dack_o,
  input logic       full_o,
  input logic       empty_o,
  input logic       invalidating_o,
  input logic       wdog_o
);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !fill_ready_o);

  assert_dack_cond_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> (run_i && dreq_i && !empty_o && !invalidating_o));

  assert_mwdma_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(invalidating_o) |-> $past(mode_i) == 2'd1);

  assert_flush_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(invalidating_o) |=> invalidating_o);

  assert_flush_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalidating_o && $past(invalidating_o)) |=> !invalidating_o);

  assert_flush_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(invalidating_o) |-> empty_o);

  assert_fill_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalidating_o |-> !fill_ready_o);

  assert_stop_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> (empty_o && !invalidating_o && !wdog_o));

  assert_wdog_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wdog_o) && $past(run_i)) |-> wdog_o);
endmodule

bind ide_dma_wr_fifo dmaw_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .run_i         (run_i),
  .mode_i        (mode_i),
  .dreq_i        (dreq_i),
  .fill_ready_o  (fill_ready_o),
  .dack_o        (dack_o),
  .full_o        (full_o),
  .empty_o       (empty_o),
  .invalidating_o(invalidating_o),
  .wdog_o        (wdog_o)
);

// File: tb/test_ide_dma_wr_fifo.sv
module test_ide_dma_wr_fifo;
  localparam int WIDTH = 32;
  localparam int DEPTH = 16;
  localparam int IDLE  = 33;
  localparam int WD_W  = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic [1:0]       mode = 2'd1;
  logic [WD_W-1:0]  wd_limit = WD_W'(1000);
  logic             fill_valid = 1'b0;
  logic [WIDTH-1:0] fill_data = '0;
  logic             fill_ready;
  logic             dreq = 1'b0;
  logic             dack;
  logic [WIDTH-1:0] dev_data;
  logic             full, empty, inval, wdog;
  logic [LVL_W-1:0] level;

  int n_chk = 0;
  int n_err = 0;
  int n_pop = 0;
  logic [WIDTH-1:0] exp_q[$];

  always #2 clk = ~clk;

  ide_dma_wr_fifo #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .IDLE_CYCLES(IDLE), .WD_W(WD_W)
  ) i_ide_dma_wr_fifo (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .mode_i(mode),
    .wdog_limit_i(wd_limit), .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .fill_ready_o(fill_ready), .dreq_i(dreq), .dack_o(dack), .dev_data_o(dev_data),
    .full_o(full), .empty_o(empty), .level_o(level),
    .invalidating_o(inval), .wdog_o(wdog)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_word(input logic [WIDTH-1:0] d);
    fill_valid = 1'b1;
    fill_data  = d;
    exp_q.push_back(d);
    step(1);
    fill_valid = 1'b0;
  endtask

  // monitor: pops expected words as the design acknowledges (R2, R4)
  always @(negedge clk) begin
    if (rst_n && dack) begin
      n_pop++;
      if (!dreq) check("R4 dack without dreq", 32'(dack), 32'd0);
      if (exp_q.size() == 0) begin
        check("R2 unexpected word", dev_data, 32'hxxxx_xxxx);
      end else begin
        check("R2 data order", dev_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int p0;
    logic seen;
    step(3);
    // R1 reset state
    check("R1 empty", 32'(empty), 32'd1);
    check("R1 full", 32'(full), 32'd0);
    check("R1 level", 32'(level), 32'd0);
    check("R1 dack", 32'(dack), 32'd0);
    check("R1 inval", 32'(inval), 32'd0);
    check("R1 wdog", 32'(wdog), 32'd0);
    rst_n = 1'b1;
    step(1);
    run = 1'b1;
    step(1);

    // R2 basic ordered delivery
    for (int i = 0; i < 4; i++) push_word(32'hA000_0000 + 32'(i));
    check("R2 level", 32'(level), 32'd4);
    p0 = n_pop;
    dreq = 1'b1;
    step(6);
    check("R2 pops", 32'(n_pop - p0), 32'd4);
    check("R2 empty", 32'(empty), 32'd1);
    check("R4 no dack when empty", 32'(dack), 32'd0);
    mode = 2'd0;
    dreq = 1'b0;

    // R3 full and overfill
    for (int i = 0; i < DEPTH; i++) push_word(32'hB000_0000 + 32'(i));
    check("R3 full", 32'(full), 32'd1);
    check("R3 ready low", 32'(fill_ready), 32'd0);
    fill_valid = 1'b1;
    fill_data  = 32'hDEAD_BEEF;
    step(4);
    fill_valid = 1'b0;
    check("R3 level", 32'(level), 32'(DEPTH));
    p0 = n_pop;
    dreq = 1'b1;
    step(DEPTH + 3);
    check("R3 pops", 32'(n_pop - p0), 32'(DEPTH));
    check("R3 empty", 32'(empty), 32'd1);

    // R5/R6/R7 idle flush with a fill arriving during it
    mode = 2'd1;
    step(2);
    dreq = 1'b0;
    for (int i = 0; i < 3; i++) push_word(32'hC000_0000 + 32'(i));
    step(IDLE - 4);
    check("R5 not early", 32'(inval), 32'd0);
    check("R5 level", 32'(level), 32'd3);
    step(1);
    check("R5 flush starts", 32'(inval), 32'd1);
    fill_valid = 1'b1;
    fill_data  = 32'hBAD0_0001;
    check("R7 ready low", 32'(fill_ready), 32'd0);
    step(1);
    check("R6 flush 2nd cycle", 32'(inval), 32'd1);
    check("R7 ready low 2", 32'(fill_ready), 32'd0);
    step(1);
    fill_valid = 1'b0;
    check("R6 flush done", 32'(inval), 32'd0);
    check("R7 empty after", 32'(empty), 32'd1);
    check("R7 level after", 32'(level), 32'd0);
    exp_q.delete();

    // R8 recovery after flush
    step(IDLE + 2);
    check("R8 no reflush", 32'(inval), 32'd0);
    push_word(32'hD000_0001);
    push_word(32'hD000_0002);
    p0 = n_pop;
    dreq = 1'b1;
    step(4);
    check("R8 pops", 32'(n_pop - p0), 32'd2);
    check("R8 empty", 32'(empty), 32'd1);

    // R9 PIO and UDMA never flush
    for (int m = 0; m < 3; m += 2) begin
      mode = 2'(m);
      dreq = 1'b1;
      step(2);
      dreq = 1'b0;
      seen = 1'b0;
      for (int k = 0; k < IDLE + 6; k++) begin
        step(1);
        if (inval) seen = 1'b1;
      end
      check("R9 no flush", 32'(seen), 32'd0);
    end

    // R11 watchdog
    mode = 2'd0;
    wd_limit = WD_W'(5);
    step(1);
    dreq = 1'b1;
    step(4);
    check("R11 not yet", 32'(wdog), 32'd0);
    step(1);
    check("R11 trips", 32'(wdog), 32'd1);
    dreq = 1'b0;
    step(3);
    check("R11 sticky", 32'(wdog), 32'd1);

    // R10 stop clears and blocks, restart works
    push_word(32'hE000_0001);
    run = 1'b0;
    step(1);
    exp_q.delete();
    check("R10 empty", 32'(empty), 32'd1);
    check("R10 wdog clr", 32'(wdog), 32'd0);
    fill_valid = 1'b1;
    fill_data  = 32'hBAD0_0002;
    dreq = 1'b1;
    check("R10 ready low", 32'(fill_ready), 32'd0);
    check("R10 no dack", 32'(dack), 32'd0);
    step(2);
    fill_valid = 1'b0;
    dreq = 1'b0;
    check("R10 level", 32'(level), 32'd0);
    wd_limit = WD_W'(1000);
    run = 1'b1;
    step(1);
    push_word(32'hF000_0001);
    push_word(32'hF000_0002);
    p0 = n_pop;
    dreq = 1'b1;
    step(4);
    check("R10 restart pops", 32'(n_pop - p0), 32'd2);
    check("R10 queue drained", 32'(exp_q.size()), 32'd0);
    dreq = 1'b0;
    step(2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule